// File: doc/BRIEF.md
# Counter Overflow Interrupt Aggregator

This block pairs a 16-bit up-counter with a combiner that reduces eight event flags to one interrupt request. Two of the flags come from the counter. One records a full wrap of all 16 bits. The other records a wrap of a low-order field whose width is selectable as 8, 9, 10 or 11 bits. The remaining six flags are raised by single-cycle pulses from external capture/compare channels. A flag latches whenever its event occurs. Its enable has no influence on whether the flag is set.

A small register port gives software access to the block. Through it, software reads the flags and clears them by writing zeros, programs the eight per-flag enables, sets two global enables and the field-width select, and reads the counter. The interrupt request is the OR of every flag ANDed with its enable, gated by both global enables. A two-state machine turns that request into a registered output. The machine has two states. In IRQ_QUIET the output is low. In IRQ_RAISED the output is high. The RAISE transition goes from IRQ_QUIET to IRQ_RAISED when the gated request is 1. The DROP transition goes from IRQ_RAISED to IRQ_QUIET when the request is 0. In every other case the machine stays in its state.

Top module: `ovf_irq_aggregator`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), the counter, all flags, all enables and the control register are zero, and `irq` is 0.
- R2: At each clock edge with `count_en` high, the counter advances by one, wrapping from 0xFFFF to 0x0000. With `count_en` low it holds its value. It is read at address 3 (bits 7:0) and address 4 (bits 15:8).
- R3: Flag bit 0 (full wrap) is set at the edge where the counter goes from 0xFFFF to 0x0000.
- R4: Flag bit 1 (field wrap) is set at the edge where the low field of the counter goes from all ones to zero. The field width is 8 plus the control select value in bits 3:2 (00=8, 01=9, 10=10, 11=11 bits).
- R5: A pulse on `chan_evt[n]` sets flag bit n+2 at that clock edge.
- R6: Flags are set by their events whatever the state of the enables and the global enables.
- R7: Flags are sticky. A write to address 0 clears each flag whose data bit is 0 and leaves the flags whose data bit is 1. When a flag's set event and its clear fall in the same cycle, the flag ends set. Flags are read at address 0.
- R8: `irq` equals, one clock later, the OR over all eight (flag AND enable) pairs, ANDed with control bit 0 (global enable) and control bit 1 (module enable).
- R9: Address 1 holds the eight enables, in the same bit order as the flags. Address 2 holds control bits 3:0, and its bits 7:4 read as 0. Addresses 5 to 7 read as 0. Writes to addresses 3 to 7 change nothing.
- R10: While either global enable bit is 0, `irq` is 0 from the next clock onward, even with enabled flags set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| count_en | input | 1 | Counter advance enable |
| chan_evt | input | 6 | Channel event pulses, one per channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data, combinational from `rd_addr` |
| irq | output | 1 | Registered interrupt request |

## Verification
Each event or write takes effect at the clock edge on which it is presented. The next read of a flag, enable, control or count value therefore shows the new value. `rd_data` follows `rd_addr` within the same cycle. `irq` lags flags and enables by one further edge, because the gate state machine registers the request. The bench drives inputs at the falling edge and compares outputs shortly after it. A reference model is advanced at each rising edge, and the interrupt it predicts is computed from the model state held before that edge. This reproduces the one-cycle lag of `irq` and the same-edge update of the flags.

// File: rtl/ovf_irq_pkg.sv
package ovf_irq_pkg;

    // Flag and enable bit positions
    localparam int FLAG_FULL  = 0;
    localparam int FLAG_FIELD = 1;
    localparam int FLAG_CHAN0 = 2;

    // Control register bit positions
    localparam int CTL_GLOBAL = 0;
    localparam int CTL_MODULE = 1;
    localparam int CTL_SEL_LO = 2;
    localparam int CTL_BITS   = 4;

    // Register addresses
    localparam int ADDR_FLAGS  = 0;
    localparam int ADDR_ENABLE = 1;
    localparam int ADDR_CTRL   = 2;
    localparam int ADDR_CNT_LO = 3;
    localparam int ADDR_CNT_HI = 4;

    typedef enum logic [1:0] {
        FIELD_8  = 2'd0,
        FIELD_9  = 2'd1,
        FIELD_10 = 2'd2,
        FIELD_11 = 2'd3
    } field_sel_e;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

endpackage

// File: rtl/ovf_counter.sv
module ovf_counter
    import ovf_irq_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int FIELD_BASE = 8,
    parameter int FIELD_OPTS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             count_en,
    input  field_sel_e       field_sel,
    output logic [CNT_W-1:0] count,
    output logic             full_wrap,
    output logic             field_wrap
);

    logic [CNT_W-1:0]      count_q;
    logic [FIELD_OPTS-1:0] field_ones;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (count_en) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    // One all-ones detector per selectable field width
    for (genvar k = 0; k < FIELD_OPTS; k++) begin : g_field
        assign field_ones[k] = &count_q[FIELD_BASE+k-1:0];
    end

    always_comb begin
        full_wrap  = count_en && (&count_q);
        field_wrap = count_en && field_ones[field_sel];
    end

    assign count = count_q;

    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        count_en |=> count_q == $past(count_q) + CNT_W'(1));

    p_count_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !count_en |=> $stable(count_q));

    p_full_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        full_wrap |=> count_q == '0);

endmodule

// File: rtl/ovf_reg_file.sv
module ovf_reg_file
    import ovf_irq_pkg::*;
#(
    parameter int NUM_CHAN = 6,
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 3,
    parameter int CNT_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] set_vec,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] flags,
    output logic [DATA_W-1:0] enables,
    output logic              glob_en,
    output logic              mod_en,
    output field_sel_e        field_sel,
    output logic [DATA_W-1:0] rd_data
);

    localparam int NUM_FLAGS = NUM_CHAN + FLAG_CHAN0;
    localparam int HI_W      = CNT_W - DATA_W;

    logic [DATA_W-1:0]   flags_q;
    logic [DATA_W-1:0]   enables_q;
    logic [CTL_BITS-1:0] ctrl_q;
    logic [DATA_W-1:0]   clr_vec;
    logic                wr_flags;
    logic                wr_enable;
    logic                wr_ctrl;

    always_comb begin
        wr_flags  = wr_en && (wr_addr == ADDR_W'(ADDR_FLAGS));
        wr_enable = wr_en && (wr_addr == ADDR_W'(ADDR_ENABLE));
        wr_ctrl   = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
        clr_vec   = wr_flags ? ~wr_data : '0;
    end

    // Sticky flags: a set event outranks a clear in the same cycle
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flags_q[i] <= 1'b0;
            end else if (set_vec[i]) begin
                flags_q[i] <= 1'b1;
            end else if (clr_vec[i]) begin
                flags_q[i] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enables_q <= '0;
            ctrl_q    <= '0;
        end else begin
            if (wr_enable) begin
                enables_q <= wr_data;
            end
            if (wr_ctrl) begin
                ctrl_q <= wr_data[CTL_BITS-1:0];
            end
        end
    end

    always_comb begin
        unique case (rd_addr)
            ADDR_W'(ADDR_FLAGS):  rd_data = flags_q;
            ADDR_W'(ADDR_ENABLE): rd_data = enables_q;
            ADDR_W'(ADDR_CTRL):   rd_data = DATA_W'(ctrl_q);
            ADDR_W'(ADDR_CNT_LO): rd_data = count[DATA_W-1:0];
            ADDR_W'(ADDR_CNT_HI): rd_data = DATA_W'(count[CNT_W-1:CNT_W-HI_W]);
            default:              rd_data = '0;
        endcase
    end

    assign flags     = flags_q;
    assign enables   = enables_q;
    assign glob_en   = ctrl_q[CTL_GLOBAL];
    assign mod_en    = ctrl_q[CTL_MODULE];
    assign field_sel = field_sel_e'(ctrl_q[CTL_SEL_LO+1:CTL_SEL_LO]);

    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));

    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        !wr_flags |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    p_enable_write_r9: assert property (@(posedge clk) disable iff (rst)
        wr_enable |=> enables_q == $past(wr_data));

endmodule

// File: rtl/ovf_irq_gate.sv
module ovf_irq_gate
    import ovf_irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] flags,
    input  logic [DATA_W-1:0] enables,
    input  logic              glob_en,
    input  logic              mod_en,
    output logic              irq
);

    irq_state_e state_q;
    irq_state_e state_d;
    logic       req;

    always_comb begin
        req = (|(flags & enables)) && glob_en && mod_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (req)  state_d = IRQ_RAISED; // RAISE
            IRQ_RAISED: if (!req) state_d = IRQ_QUIET;  // DROP
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_RAISED);
    end

    p_irq_follow_r8: assert property (@(posedge clk) disable iff (rst)
        req |=> irq);

    p_irq_release_r8: assert property (@(posedge clk) disable iff (rst)
        !req |=> !irq);

    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !(glob_en && mod_en) |=> !irq);

endmodule

// File: rtl/ovf_irq_aggregator.sv
module ovf_irq_aggregator
    import ovf_irq_pkg::*;
#(
    parameter int NUM_CHAN   = 6,
    parameter int CNT_W      = 16,
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 3,
    parameter int FIELD_BASE = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                count_en,
    input  logic [NUM_CHAN-1:0] chan_evt,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    output logic                irq
);

    localparam int FIELD_OPTS = 4;

    logic [CNT_W-1:0]  count;
    logic              full_wrap;
    logic              field_wrap;
    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] flags;
    logic [DATA_W-1:0] enables;
    logic              glob_en;
    logic              mod_en;
    field_sel_e        field_sel;

    always_comb begin
        set_vec = '0;
        set_vec[FLAG_FULL]  = full_wrap;
        set_vec[FLAG_FIELD] = field_wrap;
        set_vec[FLAG_CHAN0 +: NUM_CHAN] = chan_evt;
    end

    ovf_counter #(
        .CNT_W      (CNT_W),
        .FIELD_BASE (FIELD_BASE),
        .FIELD_OPTS (FIELD_OPTS)
    ) i_counter (
        .clk        (clk),
        .rst        (rst),
        .count_en   (count_en),
        .field_sel  (field_sel),
        .count      (count),
        .full_wrap  (full_wrap),
        .field_wrap (field_wrap)
    );

    ovf_reg_file #(
        .NUM_CHAN (NUM_CHAN),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .CNT_W    (CNT_W)
    ) i_regs (
        .clk       (clk),
        .rst       (rst),
        .set_vec   (set_vec),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .count     (count),
        .flags     (flags),
        .enables   (enables),
        .glob_en   (glob_en),
        .mod_en    (mod_en),
        .field_sel (field_sel),
        .rd_data   (rd_data)
    );

    ovf_irq_gate #(
        .DATA_W (DATA_W)
    ) i_gate (
        .clk     (clk),
        .rst     (rst),
        .flags   (flags),
        .enables (enables),
        .glob_en (glob_en),
        .mod_en  (mod_en),
        .irq     (irq)
    );

    p_chan_latch_r5: assert property (@(posedge clk) disable iff (rst)
        (chan_evt != '0) |=> ((flags[FLAG_CHAN0 +: NUM_CHAN] & $past(chan_evt)) == $past(chan_evt)));

    p_field_latch_r4: assert property (@(posedge clk) disable iff (rst)
        field_wrap |=> flags[FLAG_FIELD]);

endmodule

// File: tb/test_ovf_irq_aggregator.sv
module test_ovf_irq_aggregator;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       count_en = 1'b0;
    logic [5:0] chan_evt = '0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       irq;

    int  n_vec  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    // Reference model state
    logic [15:0] m_cnt   = '0;
    logic [7:0]  m_flags = '0;
    logic [7:0]  m_en    = '0;
    logic [3:0]  m_ctl   = '0;
    logic        m_irq   = 1'b0;

    always #10 clk = ~clk;

    ovf_irq_aggregator i_ovf_irq_aggregator (
        .clk      (clk),
        .rst      (rst),
        .count_en (count_en),
        .chan_evt (chan_evt),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .irq      (irq)
    );

    function automatic logic [7:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0:    return m_flags;
            3'd1:    return m_en;
            3'd2:    return {4'b0, m_ctl};
            3'd3:    return m_cnt[7:0];
            3'd4:    return m_cnt[15:8];
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic field_wrap_exp(input logic ce);
        logic [15:0] mask;
        mask = 16'((32'd1 << (8 + int'(m_ctl[3:2]))) - 1);
        return ce && ((m_cnt & mask) == mask);
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic step(input logic ce, input logic [5:0] ev, input logic we,
                        input logic [2:0] wa, input logic [7:0] wd,
                        input logic [2:0] ra, input string tag);
        logic [7:0] set_v;
        logic [7:0] clr_v;
        logic       req;
        @(negedge clk);
        count_en = ce; chan_evt = ev; wr_en = we;
        wr_addr = wa; wr_data = wd; rd_addr = ra;
        #1;
        check(tag, rd_data, exp_read(ra));
        check((tag == "R10" || tag == "R1") ? tag : "R8", {7'b0, irq}, {7'b0, m_irq});
        @(posedge clk);
        req   = (|(m_flags & m_en)) && m_ctl[0] && m_ctl[1];
        set_v = {ev, field_wrap_exp(ce), ce && (m_cnt == 16'hFFFF)};
        clr_v = (we && wa == 3'd0) ? ~wd : 8'h00;
        m_flags = (m_flags & ~clr_v) | set_v;
        if (we && wa == 3'd1) m_en  = wd;
        if (we && wa == 3'd2) m_ctl = wd[3:0];
        if (ce) m_cnt = m_cnt + 16'd1;
        m_irq = req;
    endtask

    task automatic idle(input logic [2:0] ra, input string tag);
        step(1'b0, 6'h00, 1'b0, 3'd0, 8'h00, ra, tag);
    endtask

    task automatic wr(input logic [2:0] wa, input logic [7:0] wd, input string tag);
        step(1'b0, 6'h00, 1'b1, wa, wd, 3'd0, tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin : stimulus
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state on every readable address
        for (int a = 0; a < 5; a++) idle(3'(a), "R1");

        // R6: channel 3 pulse with all enables off still latches bit 5
        step(1'b0, 6'b001000, 1'b0, 3'd0, 8'h00, 3'd0, "R6");
        idle(3'd0, "R6");
        // R8: enable bit 5 and both globals, irq follows one cycle later
        wr(3'd1, 8'h20, "R8");
        wr(3'd2, 8'h03, "R8");
        idle(3'd2, "R8");
        idle(3'd0, "R8");
        // R10: module enable off drops irq
        wr(3'd2, 8'h01, "R10");
        idle(3'd0, "R10");
        idle(3'd0, "R10");
        wr(3'd2, 8'h02, "R10");
        idle(3'd0, "R10");
        wr(3'd2, 8'h03, "R8");
        idle(3'd0, "R8");
        // R7: clear of bit 5 together with a new channel 3 event, set wins
        step(1'b0, 6'b001000, 1'b1, 3'd0, 8'hDF, 3'd0, "R7");
        idle(3'd0, "R7");
        // R7: clear without event
        wr(3'd0, 8'hDF, "R7");
        idle(3'd0, "R7");
        idle(3'd0, "R8");
        // R5: each channel pulse sets its own bit
        for (int c = 0; c < 6; c++) begin
            step(1'b0, 6'(1 << c), 1'b0, 3'd0, 8'h00, 3'd0, "R5");
            idle(3'd0, "R5");
        end
        // R9: unused addresses, read-only count, control upper bits
        wr(3'd3, 8'h55, "R9");
        wr(3'd6, 8'hAA, "R9");
        idle(3'd3, "R9");
        idle(3'd6, "R9");
        wr(3'd2, 8'hF3, "R9");
        idle(3'd2, "R9");

        // R4: 10-bit field wrap
        wr(3'd2, 8'h0B, "R4");
        wr(3'd0, 8'h00, "R4");
        while ((m_cnt & 16'h03FF) != 16'h03FF) step(1'b1, 6'h00, 1'b0, 3'd0, 8'h00, 3'd0, "R4");
        step(1'b1, 6'h00, 1'b0, 3'd0, 8'h00, 3'd0, "R4");
        idle(3'd0, "R4");
        idle(3'd3, "R2");

        // Constrained random mix
        for (int i = 0; i < 3000; i++) begin
            logic       ce;
            logic [5:0] ev;
            logic       we;
            logic [2:0] wa;
            logic [7:0] wd;
            logic [2:0] ra;
            string      tg;
            ce = ($urandom % 10) < 7;
            ev = ($urandom % 8 == 0) ? 6'(1 << ($urandom % 6)) : 6'h00;
            we = ($urandom % 4 == 0);
            wa = 3'($urandom % 8);
            wd = 8'($urandom);
            if (wa == 3'd0) wd = wd | 8'hF0;
            ra = 3'($urandom % 8);
            tg = (ra == 3'd0) ? "R7" : ((ra == 3'd3 || ra == 3'd4) ? "R2" : "R9");
            step(ce, ev, we, wa, wd, ra, tg);
        end

        // R3: run to the full 16-bit wrap
        wr(3'd0, 8'h00, "R3");
        while (m_cnt != 16'hFFFF) step(1'b1, 6'h00, 1'b0, 3'd0, 8'h00, 3'd4, "R2");
        step(1'b1, 6'h00, 1'b0, 3'd0, 8'h00, 3'd0, "R3");
        idle(3'd0, "R3");
        idle(3'd3, "R3");
        idle(3'd4, "R3");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule